// File: doc/BRIEF.md
# Programmed-I/O Transfer Port

This block lets a host processor stand in for a bus-master DMA engine. Control logic arms a transfer by naming one of several local byte buffers, a starting index into it and a byte count. The port then raises its data-request line. The host answers that request by reading or writing the port at 8 or 16 bits. Each accepted access moves one or two bytes between the host data bus and the selected buffer, advances the buffer index and shrinks the remaining count. Host writes also count down a shared 24-bit transfer counter.

When the remaining count reaches zero, the request line drops and a single-cycle done pulse tells the completion logic to act. At that moment the number of bytes moved is available as the difference between the current and starting indices. The byte storage itself lives outside the block. The port only presents an index, two byte lanes and the lane write enables: lane 0 addresses the current index and lane 1 the index after it.

A three-state machine sequences each transfer:
- **IDLE**: no transfer is pending.
- **ACTIVE**: bytes remain to be moved, and the request line is high.
- **FINISH**: a one-cycle state that carries the done pulse.

The transitions are:
- *arm-go*: arming with a nonzero count, from any state, leads to ACTIVE.
- *arm-empty*: arming with a zero count, from any state, leads to FINISH.
- *drain*: the access that moves the last byte leads from ACTIVE to FINISH.
- *retire*: FINISH returns to IDLE on the next cycle unless the port is armed again.

Top module: `pdma_port`

## Requirements
- R1: Arming (`arm_i` high at a clock edge) loads the buffer select, start index and byte count. After that edge `buf_sel_o` shows the buffer, `buf_addr_o` shows the start index, `xfer_count_o` is 0 and `drq_o` is 1 (count nonzero). Arming overrides an access in the same cycle and restarts a transfer in progress.
- R2: An access with `acc_size_i` = 1 moves one byte at `buf_addr_o`. A byte write puts `acc_wdata_i[7:0]` on lane 0 with `buf_we_o` = 01. A byte read returns `{8'h00, byte at index}`. The index then advances by 1.
- R3: An access with `acc_size_i` = 2 and at least two bytes remaining moves two bytes, with the higher-order byte at the lower index. A write puts `acc_wdata_i[15:8]` on lane 0 (index) and `acc_wdata_i[7:0]` on lane 1 (index+1), with `buf_we_o` = 11. A read returns `{byte at index, byte at index+1}`. The index advances by 2.
- R4: A halfword access with exactly one byte remaining moves only one byte and the count ends at zero. A write stores `acc_wdata_i[15:8]` at the index with `buf_we_o` = 01. A read returns `{byte at index, 8'h00}`.
- R5: A write is ignored (no lane enable, no index or counter change) when the transfer counter or the remaining count is zero. A read with zero remaining count returns 0 and moves nothing.
- R6: Each accepted write lowers `tc_o` by the bytes moved, saturating at zero. Reads leave `tc_o` alone. `tc_load_i` sets `tc_o` to `tc_load_val_i` and takes precedence over a same-cycle write.
- R7: The access that moves the last byte causes `drq_o` to be 0 and `done_o` to be 1 after its edge. `done_o` lasts exactly one cycle unless the port is re-armed.
- R8: An access whose `acc_size_i` is 0 or 3 is ignored: no lane enable, read data 0, no index change.
- R9: `xfer_count_o` always equals the current index minus the start index, modulo the buffer size.
- R10: Arming with a count of zero leaves `drq_o` at 0 and gives a one-cycle `done_o` after the arming edge.
- R11: During and right after reset, `drq_o`, `done_o`, `tc_o`, `xfer_count_o` and `buf_addr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arm a new transfer this cycle |
| arm_sel_i | input | SEL_W | Buffer select for the new transfer |
| arm_start_i | input | IDX_W | Start index for the new transfer |
| arm_len_i | input | LEN_W | Byte count for the new transfer |
| tc_load_i | input | 1 | Load the transfer counter |
| tc_load_val_i | input | TC_W | Value loaded into the transfer counter |
| acc_valid_i | input | 1 | Host access to the port this cycle |
| acc_write_i | input | 1 | 1 = host write, 0 = host read |
| acc_size_i | input | 2 | Access size in bytes (1 or 2 accepted) |
| acc_wdata_i | input | 16 | Host write data |
| acc_rdata_o | output | 16 | Host read data (combinational) |
| buf_rbyte0_i | input | 8 | Buffer byte at `buf_addr_o` |
| buf_rbyte1_i | input | 8 | Buffer byte at `buf_addr_o`+1 |
| buf_sel_o | output | SEL_W | Selected buffer |
| buf_addr_o | output | IDX_W | Current buffer index |
| buf_we_o | output | 2 | Lane write enables (bit 0: index, bit 1: index+1) |
| buf_wbyte0_o | output | 8 | Lane 0 write byte |
| buf_wbyte1_o | output | 8 | Lane 1 write byte |
| tc_o | output | TC_W | Shared transfer counter |
| drq_o | output | 1 | Data request to the host |
| done_o | output | 1 | One-cycle completion pulse |
| xfer_count_o | output | IDX_W | Bytes moved since arming |

## Verification
The checker watches a set of invariants on every cycle:
- a lane write enable appears only while the request line is high;
- a read outside a transfer returns zero;
- a byte write with a nonzero counter lowers it by exactly one;
- a write against a zero counter leaves it at zero;
- illegal sizes never enable a lane;
- the done pulse never overlaps the request and never repeats without a re-arm;
- a falling request is always accompanied by done.

The bench's scenarios cover what needs knowledge of a whole transfer:
- the big-endian placement of halfword bytes in the buffer;
- the single-byte tail of a halfword on an odd count;
- the final counter value after a run of mixed accesses;
- restarting a transfer mid-way;
- the zero-count arm.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FINISH = 2'd2
    } pdma_state_e;

    localparam logic [1:0] SIZE_BYTE = 2'd1;
    localparam logic [1:0] SIZE_HALF = 2'd2;
endpackage

// File: rtl/pdma_lanes.sv
// Access decode and byte-lane steering: decides whether an access is
// accepted, how many bytes it moves, and how data maps onto the lanes.
module pdma_lanes #(
    parameter int LEN_W = 8
) (
    input  logic             acc_valid_i,
    input  logic             acc_write_i,
    input  logic [1:0]       acc_size_i,
    input  logic [15:0]      acc_wdata_i,
    input  logic [7:0]       rbyte0_i,
    input  logic [7:0]       rbyte1_i,
    input  logic [LEN_W-1:0] len_rem_i,
    input  logic             tc_zero_i,
    output logic             go_o,
    output logic             move_two_o,
    output logic [1:0]       lane_we_o,
    output logic [7:0]       lane0_o,
    output logic [7:0]       lane1_o,
    output logic [15:0]      rdata_o
);
    import pdma_pkg::*;

    logic size_ok;
    logic is_half;
    logic has_len;
    logic two_left;
    logic wr_block;

    always_comb begin
        is_half  = (acc_size_i == SIZE_HALF);
        size_ok  = (acc_size_i == SIZE_BYTE) || is_half;
        has_len  = (len_rem_i != '0);
        two_left = (len_rem_i > LEN_W'(1));
        wr_block = acc_write_i && tc_zero_i;
        go_o       = acc_valid_i && size_ok && has_len && !wr_block;
        move_two_o = go_o && is_half && two_left;
    end

    always_comb begin
        lane_we_o[0] = go_o && acc_write_i;
        lane_we_o[1] = move_two_o && acc_write_i;
        lane0_o      = is_half ? acc_wdata_i[15:8] : acc_wdata_i[7:0];
        lane1_o      = acc_wdata_i[7:0];
    end

    always_comb begin
        rdata_o = 16'h0000;
        if (go_o && !acc_write_i) begin
            if (is_half) begin
                rdata_o[15:8] = rbyte0_i;
                rdata_o[7:0]  = move_two_o ? rbyte1_i : 8'h00;
            end else begin
                rdata_o[7:0]  = rbyte0_i;
            end
        end
    end
endmodule

// File: rtl/pdma_counters.sv
// Index, remaining-count and transfer-counter registers.
module pdma_counters #(
    parameter int IDX_W = 6,
    parameter int LEN_W = 8,
    parameter int TC_W  = 24,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [SEL_W-1:0] arm_sel_i,
    input  logic [IDX_W-1:0] arm_start_i,
    input  logic [LEN_W-1:0] arm_len_i,
    input  logic             tc_load_i,
    input  logic [TC_W-1:0]  tc_load_val_i,
    input  logic             go_i,
    input  logic             move_two_i,
    input  logic             is_write_i,
    output logic [SEL_W-1:0] sel_o,
    output logic [IDX_W-1:0] start_o,
    output logic [IDX_W-1:0] cur_o,
    output logic [LEN_W-1:0] len_o,
    output logic [TC_W-1:0]  tc_o,
    output logic             last_o
);
    logic [LEN_W-1:0] moved_len;
    logic [IDX_W-1:0] moved_idx;
    logic [TC_W-1:0]  moved_tc;
    logic [TC_W-1:0]  tc_dec;

    always_comb begin
        moved_len = move_two_i ? LEN_W'(2) : LEN_W'(1);
        moved_idx = move_two_i ? IDX_W'(2) : IDX_W'(1);
        moved_tc  = move_two_i ? TC_W'(2)  : TC_W'(1);
        tc_dec    = (tc_o < moved_tc) ? '0 : (tc_o - moved_tc);
        last_o    = go_i && (len_o == moved_len);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_o   <= '0;
            start_o <= '0;
            cur_o   <= '0;
            len_o   <= '0;
        end else if (arm_i) begin
            sel_o   <= arm_sel_i;
            start_o <= arm_start_i;
            cur_o   <= arm_start_i;
            len_o   <= arm_len_i;
        end else if (go_i) begin
            cur_o   <= cur_o + moved_idx;
            len_o   <= len_o - moved_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_o <= '0;
        end else if (tc_load_i) begin
            tc_o <= tc_load_val_i;
        end else if (go_i && is_write_i && !arm_i) begin
            tc_o <= tc_dec;
        end
    end
endmodule

// File: rtl/pdma_fsm.sv
// Transfer sequencer: IDLE / ACTIVE / FINISH.
module pdma_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic arm_empty_i,
    input  logic last_i,
    output logic drq_o,
    output logic done_o
);
    import pdma_pkg::*;

    pdma_state_e state_q;
    pdma_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_i) state_d = arm_empty_i ? ST_FINISH : ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (arm_i)       state_d = arm_empty_i ? ST_FINISH : ST_ACTIVE;
                else if (last_i) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                if (arm_i) state_d = arm_empty_i ? ST_FINISH : ST_ACTIVE;
                else       state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        drq_o  = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ACTIVE: drq_o  = 1'b1;
            ST_FINISH: done_o = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/pdma_port.sv
module pdma_port #(
    parameter int IDX_W = 6,
    parameter int LEN_W = 8,
    parameter int TC_W  = 24,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [SEL_W-1:0] arm_sel_i,
    input  logic [IDX_W-1:0] arm_start_i,
    input  logic [LEN_W-1:0] arm_len_i,
    input  logic             tc_load_i,
    input  logic [TC_W-1:0]  tc_load_val_i,
    input  logic             acc_valid_i,
    input  logic             acc_write_i,
    input  logic [1:0]       acc_size_i,
    input  logic [15:0]      acc_wdata_i,
    output logic [15:0]      acc_rdata_o,
    input  logic [7:0]       buf_rbyte0_i,
    input  logic [7:0]       buf_rbyte1_i,
    output logic [SEL_W-1:0] buf_sel_o,
    output logic [IDX_W-1:0] buf_addr_o,
    output logic [1:0]       buf_we_o,
    output logic [7:0]       buf_wbyte0_o,
    output logic [7:0]       buf_wbyte1_o,
    output logic [TC_W-1:0]  tc_o,
    output logic             drq_o,
    output logic             done_o,
    output logic [IDX_W-1:0] xfer_count_o
);
    logic             go;
    logic             move_two;
    logic             last;
    logic [IDX_W-1:0] start_q;
    logic [IDX_W-1:0] cur_q;
    logic [LEN_W-1:0] len_q;
    logic [TC_W-1:0]  tc_q;
    logic             arm_empty;

    assign arm_empty = (arm_len_i == '0);

    pdma_lanes #(.LEN_W(LEN_W)) u_lanes (
        .acc_valid_i (acc_valid_i),
        .acc_write_i (acc_write_i),
        .acc_size_i  (acc_size_i),
        .acc_wdata_i (acc_wdata_i),
        .rbyte0_i    (buf_rbyte0_i),
        .rbyte1_i    (buf_rbyte1_i),
        .len_rem_i   (len_q),
        .tc_zero_i   (tc_q == '0),
        .go_o        (go),
        .move_two_o  (move_two),
        .lane_we_o   (buf_we_o),
        .lane0_o     (buf_wbyte0_o),
        .lane1_o     (buf_wbyte1_o),
        .rdata_o     (acc_rdata_o)
    );

    pdma_counters #(
        .IDX_W(IDX_W), .LEN_W(LEN_W), .TC_W(TC_W), .SEL_W(SEL_W)
    ) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .arm_i         (arm_i),
        .arm_sel_i     (arm_sel_i),
        .arm_start_i   (arm_start_i),
        .arm_len_i     (arm_len_i),
        .tc_load_i     (tc_load_i),
        .tc_load_val_i (tc_load_val_i),
        .go_i          (go && !arm_i),
        .move_two_i    (move_two),
        .is_write_i    (acc_write_i),
        .sel_o         (buf_sel_o),
        .start_o       (start_q),
        .cur_o         (cur_q),
        .len_o         (len_q),
        .tc_o          (tc_q),
        .last_o        (last)
    );

    pdma_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm_i),
        .arm_empty_i (arm_empty),
        .last_i      (last),
        .drq_o       (drq_o),
        .done_o      (done_o)
    );

    assign buf_addr_o   = cur_q;
    assign tc_o         = tc_q;
    assign xfer_count_o = cur_q - start_q;
endmodule

// File: rtl/pdma_port_chk.sv
module pdma_port_chk #(
    parameter int IDX_W = 6,
    parameter int LEN_W = 8,
    parameter int TC_W  = 24,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_i,
    input logic             tc_load_i,
    input logic             acc_valid_i,
    input logic             acc_write_i,
    input logic [1:0]       acc_size_i,
    input logic [15:0]      acc_rdata_o,
    input logic [1:0]       buf_we_o,
    input logic [TC_W-1:0]  tc_o,
    input logic             drq_o,
    input logic             done_o
);
    // R5: lanes only write while a transfer is pending
    p_we_needs_drq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we_o != 2'b00) |-> drq_o);

    // R5: a read outside a transfer returns zero
    p_idle_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !acc_write_i && !drq_o) |-> (acc_rdata_o == 16'h0000));

    // R5: a write with zero counter leaves it zero
    p_tc_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_write_i && tc_o == '0 && !tc_load_i) |=> (tc_o == '0));

    // R6: accepted byte write lowers the counter by one
    p_tc_byte_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && acc_write_i && drq_o && acc_size_i == 2'd1 &&
         tc_o != '0 && !tc_load_i && !arm_i) |=> (tc_o == $past(tc_o) - 1'b1));

    // R7: done never overlaps the request
    p_done_not_drq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !drq_o);

    // R7: request falls only together with done
    p_fall_gives_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drq_o) |-> done_o);

    // R7: done is a single-cycle pulse without a re-arm
    p_done_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i) |=> !done_o);

    // R8: illegal sizes never enable a lane
    p_bad_size_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && (acc_size_i == 2'd0 || acc_size_i == 2'd3)) |-> (buf_we_o == 2'b00));
endmodule

bind pdma_port pdma_port_chk #(
    .IDX_W(IDX_W), .LEN_W(LEN_W), .TC_W(TC_W), .SEL_W(SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (arm_i),
    .tc_load_i   (tc_load_i),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_size_i  (acc_size_i),
    .acc_rdata_o (acc_rdata_o),
    .buf_we_o    (buf_we_o),
    .tc_o        (tc_o),
    .drq_o       (drq_o),
    .done_o      (done_o)
);

// File: tb/sim_pdma_port.sv
`timescale 1ns/1ps
module sim_pdma_port;
    localparam int IDX_W = 6;
    localparam int LEN_W = 8;
    localparam int TC_W  = 24;
    localparam int SEL_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm_i = 1'b0;
    logic [SEL_W-1:0] arm_sel_i = '0;
    logic [IDX_W-1:0] arm_start_i = '0;
    logic [LEN_W-1:0] arm_len_i = '0;
    logic             tc_load_i = 1'b0;
    logic [TC_W-1:0]  tc_load_val_i = '0;
    logic             acc_valid_i = 1'b0;
    logic             acc_write_i = 1'b0;
    logic [1:0]       acc_size_i = 2'd1;
    logic [15:0]      acc_wdata_i = '0;
    logic [15:0]      acc_rdata_o;
    logic [7:0]       buf_rbyte0_i;
    logic [7:0]       buf_rbyte1_i;
    logic [SEL_W-1:0] buf_sel_o;
    logic [IDX_W-1:0] buf_addr_o;
    logic [1:0]       buf_we_o;
    logic [7:0]       buf_wbyte0_o;
    logic [7:0]       buf_wbyte1_o;
    logic [TC_W-1:0]  tc_o;
    logic             drq_o;
    logic             done_o;
    logic [IDX_W-1:0] xfer_count_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0] mem [64];

    always #2.5 clk = ~clk;

    pdma_port #(.IDX_W(IDX_W), .LEN_W(LEN_W), .TC_W(TC_W), .SEL_W(SEL_W)) u0 (.*);

    function automatic logic [7:0] rpat(input logic [5:0] a);
        return {a, 2'b01} ^ 8'h5A;
    endfunction

    assign buf_rbyte0_i = rpat(buf_addr_o);
    assign buf_rbyte1_i = rpat(buf_addr_o + 6'd1);

    always @(posedge clk) begin
        if (buf_we_o[0]) mem[buf_addr_o] <= buf_wbyte0_o;
        if (buf_we_o[1]) mem[buf_addr_o + 6'd1] <= buf_wbyte1_o;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic arm_xfer(input logic [1:0] sel, input logic [5:0] st, input logic [7:0] len);
        @(negedge clk);
        arm_i = 1'b1; arm_sel_i = sel; arm_start_i = st; arm_len_i = len;
        @(negedge clk);
        arm_i = 1'b0;
    endtask

    task automatic load_tc(input logic [23:0] v);
        @(negedge clk);
        tc_load_i = 1'b1; tc_load_val_i = v;
        @(negedge clk);
        tc_load_i = 1'b0;
    endtask

    task automatic access(input bit wr, input logic [1:0] sz, input logic [15:0] d,
                          output logic [15:0] rd, output logic [1:0] we);
        @(negedge clk);
        acc_valid_i = 1'b1; acc_write_i = wr; acc_size_i = sz; acc_wdata_i = d;
        #1;
        rd = acc_rdata_o;
        we = buf_we_o;
        @(posedge clk);
        #1;
        acc_valid_i = 1'b0;
    endtask

    function automatic logic [7:0] wpat(input int k, input int st, input int len);
        return 8'((k * 7) + st + (len * 13) + 17);
    endfunction

    initial begin
        logic [15:0] rd;
        logic [1:0]  we;
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(drq_o == 1'b0 && done_o == 1'b0, "R11", {drq_o, done_o}, 0);
        chk(tc_o == '0 && xfer_count_o == '0 && buf_addr_o == '0, "R11", tc_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(drq_o == 1'b0 && done_o == 1'b0, "R11", {drq_o, done_o}, 0);

        // Sweep: starts x lengths x {byte wr, half wr, byte rd, half rd}
        for (int s = 0; s < 3; s++) begin
            for (int len = 1; len <= 5; len++) begin
                for (int mode = 0; mode < 4; mode++) begin
                    automatic int st = (s == 0) ? 0 : (s == 1) ? 21 : 61;
                    automatic bit wr = (mode < 2);
                    automatic bit half = mode[0];
                    automatic int p = 0;
                    automatic logic [7:0] sentinel = mem[6'(st + len)];
                    load_tc(24'd1000);
                    arm_xfer(2'(mode), 6'(st), 8'(len));
                    // R1: arming loads select/start/index, raises request
                    chk(drq_o && xfer_count_o == 0, "R1", {drq_o, xfer_count_o}, {1'b1, 6'd0});
                    chk(buf_addr_o == 6'(st) && buf_sel_o == 2'(mode), "R1", buf_addr_o, st);
                    while (p < len) begin
                        automatic int step = (half && (len - p) >= 2) ? 2 : 1;
                        automatic logic [5:0] a = 6'(st + p);
                        automatic logic [15:0] d;
                        automatic logic [15:0] er;
                        if (half) d = {wpat(p, st, len), wpat(p + 1, st, len)};
                        else      d = {8'hEE, wpat(p, st, len)};
                        access(wr, half ? 2'd2 : 2'd1, d, rd, we);
                        if (wr) begin
                            // R2 R3 R4: lane enables per bytes moved
                            chk(we == ((step == 2) ? 2'b11 : 2'b01),
                                half ? ((step == 2) ? "R3" : "R4") : "R2", we, step);
                        end else begin
                            if (!half)          er = {8'h00, rpat(a)};
                            else if (step == 2) er = {rpat(a), rpat(a + 6'd1)};
                            else                er = {rpat(a), 8'h00};
                            chk(rd == er, half ? ((step == 2) ? "R3" : "R4") : "R2", rd, er);
                        end
                        p += step;
                        @(negedge clk);
                        // R9: bytes moved = index - start
                        chk(xfer_count_o == 6'(p), "R9", xfer_count_o, p);
                        if (p < len) chk(drq_o == 1'b1, "R7", drq_o, 1);
                    end
                    // R7: request drops, done pulses one cycle
                    chk(drq_o == 1'b0 && done_o == 1'b1, "R7", {drq_o, done_o}, 2'b01);
                    @(negedge clk);
                    chk(done_o == 1'b0, "R7", done_o, 0);
                    // R6: counter lowered only by writes
                    chk(tc_o == (wr ? 24'(1000 - len) : 24'd1000), "R6", tc_o, wr ? 1000 - len : 1000);
                    if (wr) begin
                        for (int k = 0; k < len; k++)
                            chk(mem[6'(st + k)] == wpat(k, st, len), half ? "R3" : "R2",
                                mem[6'(st + k)], wpat(k, st, len));
                        chk(mem[6'(st + len)] == sentinel, "R4", mem[6'(st + len)], sentinel);
                    end
                end
            end
        end

        // R5: writes ignored with zero counter
        load_tc(24'd0);
        arm_xfer(2'd1, 6'd10, 8'd3);
        access(1'b1, 2'd1, 16'h00AB, rd, we);
        chk(we == 2'b00, "R5", we, 0);
        @(negedge clk);
        chk(xfer_count_o == 0 && drq_o, "R5", xfer_count_o, 0);
        for (int i = 0; i < 3; i++) access(1'b0, 2'd1, 16'h0, rd, we);
        @(negedge clk);
        // R5: after completion reads return zero and writes do nothing
        load_tc(24'd9);
        access(1'b0, 2'd2, 16'h0, rd, we);
        chk(rd == 16'h0000, "R5", rd, 0);
        access(1'b1, 2'd1, 16'h0077, rd, we);
        chk(we == 2'b00, "R5", we, 0);
        @(negedge clk);
        chk(tc_o == 24'd9 && xfer_count_o == 6'd3, "R5", tc_o, 9);

        // R6: saturation at zero, then further writes ignored
        load_tc(24'd1);
        arm_xfer(2'd0, 6'd30, 8'd4);
        access(1'b1, 2'd2, 16'h1234, rd, we);
        chk(we == 2'b11, "R6", we, 3);
        @(negedge clk);
        chk(tc_o == 0 && xfer_count_o == 6'd2, "R6", tc_o, 0);
        access(1'b1, 2'd1, 16'h0055, rd, we);
        chk(we == 2'b00, "R6", we, 0);
        // R6: load wins over a same-cycle write
        @(negedge clk);
        tc_load_i = 1'b1; tc_load_val_i = 24'd50;
        acc_valid_i = 1'b1; acc_write_i = 1'b1; acc_size_i = 2'd1;
        @(negedge clk);
        tc_load_i = 1'b0; acc_valid_i = 1'b0;
        chk(tc_o == 24'd50, "R6", tc_o, 50);
        arm_xfer(2'd0, 6'd30, 8'd0);
        @(negedge clk);

        // R8: illegal sizes ignored
        arm_xfer(2'd2, 6'd40, 8'd2);
        access(1'b0, 2'd0, 16'h0, rd, we);
        chk(rd == 16'h0000, "R8", rd, 0);
        access(1'b1, 2'd3, 16'hFFFF, rd, we);
        chk(we == 2'b00, "R8", we, 0);
        @(negedge clk);
        chk(xfer_count_o == 0 && buf_addr_o == 6'd40 && drq_o, "R8", xfer_count_o, 0);

        // R10 / R1: re-arm mid-transfer restarts
        access(1'b0, 2'd1, 16'h0, rd, we);
        arm_xfer(2'd3, 6'd50, 8'd1);
        chk(drq_o && xfer_count_o == 0 && buf_addr_o == 6'd50 && buf_sel_o == 2'd3,
            "R1", buf_addr_o, 50);
        access(1'b0, 2'd1, 16'h0, rd, we);
        chk(rd == {8'h00, rpat(6'd50)}, "R2", rd, {8'h00, rpat(6'd50)});
        @(negedge clk);
        chk(done_o && !drq_o, "R7", {drq_o, done_o}, 1);

        // R10: zero-length arm
        @(negedge clk);
        arm_xfer(2'd1, 6'd5, 8'd0);
        chk(done_o == 1'b1 && drq_o == 1'b0, "R10", {drq_o, done_o}, 1);
        @(negedge clk);
        chk(done_o == 1'b0 && drq_o == 1'b0, "R10", {drq_o, done_o}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule